// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers 24 interrupt requests from board peripherals into a single combined request line for a host processor. The requests are grouped into three byte-wide banks. Each bank has a status byte and a mask byte, and both are reached over a small byte-wide register bus with read and write strobes and a 3-bit address. Every request passes through a two-flop synchroniser. Edge-type sources are captured on a rising edge, but only while their mask bit is set. One designated source is level-type: it is never latched, and its status bit follows the synchronised input.

No acknowledge register exists. Reading a status byte clears the latched edge bits of that byte, and the level source keeps reporting its live state. An edge that arrives while its source is masked is lost on purpose, and a level-type peripheral wired to an edge input can therefore be missed. The combined output is a level that stays high while any enabled source is pending. It is meant to drive a host pin that detects rising edges.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is applied and right after it is released, every mask byte reads 0x00, every status byte reads 0x00 and `irqOut` is low.
- R2: A write to offset 4, 5 or 6 loads mask byte 0, 1 or 2. Bit i of mask byte k enables source 8k+i, and a 1 enables. A read of the same offset returns the stored byte.
- R3: A rising edge on an enabled edge source sets its status bit. Status byte k is read at offset k (0, 1 or 2), and bit i of that byte is source 8k+i.
- R4: A rising edge on a source whose mask bit is 0 is not captured. Setting the mask bit afterwards neither raises `irqOut` nor shows the bit in status.
- R5: A read of a status byte clears the latched edge bits of that byte only. The other two bytes keep their bits.
- R6: If an edge is detected in the same cycle that its status byte is read, the bit stays set after the read.
- R7: Source `LEVEL_SRC` (default 13, status byte 1 bit 5) is level-type. Its status bit follows the synchronised input whatever its mask is, and status reads do not clear it.
- R8: `irqOut` is high exactly when some source has both its status bit and its mask bit set.
- R9: Reads of offsets 3 and 7 return 0x00. Writes to offsets 0 to 3 and 7 change no state.
- R10: Read data appears on `busRdata` after the clock edge that samples `busRd`. An enabled edge source raises `irqOut` after the third clock edge that follows the input change. The level source raises it after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register offset |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| reqIn | input | 24 | Asynchronous interrupt requests |
| irqOut | output | 1 | Combined pending level to the host |

## Verification
Edge capture and the clear-on-read of the same status byte can both act in one clock cycle. The bench provokes this directly: it raises a request and then issues the read of that bank two edges later, so that the read strobe is sampled on the edge that captures the bit. It judges the outcome from two observations. The read returns the byte without the new bit, and afterwards `irqOut` stays high and a second read returns the bit. The random phase also lands reads on capture cycles at random and compares every read and every output cycle against a bench model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BANK_W     = 8;
  localparam int NUM_BANKS  = 3;
  localparam int SRC_W      = BANK_W * NUM_BANKS;
  localparam int ADDR_W     = 3;
  localparam int BANK_SEL_W = ADDR_W - 1;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2,
    RD_ZERO   = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  maskWr;
    logic [NUM_BANKS-1:0]  statusRd;
    rdKind_e               rdKind;
    logic [BANK_SEL_W-1:0] rdBank;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);
  localparam logic [BANK_SEL_W-1:0] LAST_BANK = BANK_SEL_W'(NUM_BANKS - 1);

  logic [BANK_SEL_W-1:0] bankIdx;
  logic                  isMask;
  logic                  bankValid;

  assign bankIdx   = busAddr[BANK_SEL_W-1:0];
  assign isMask    = busAddr[ADDR_W-1];
  assign bankValid = (bankIdx <= LAST_BANK);

  always_comb begin
    strobes        = '0;
    strobes.rdKind = RD_NONE;
    strobes.rdBank = bankIdx;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankValid && bankIdx == BANK_SEL_W'(b)) begin
        strobes.maskWr[b]   = busWr & isMask;
        strobes.statusRd[b] = busRd & ~isMask;
      end
    end
    if (busRd) begin
      if (!bankValid)  strobes.rdKind = RD_ZERO;
      else if (isMask) strobes.rdKind = RD_MASK;
      else             strobes.rdKind = RD_STATUS;
    end
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_SRC   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_W-1:0]  reqIn,
  input  logic [BANK_W-1:0] busWdata,
  input  ctrlStrobes_t      strobes,
  output logic [BANK_W-1:0] busRdata,
  output logic              irqOut,
  output logic [SRC_W-1:0]  maskVec,
  output logic [SRC_W-1:0]  latchedVec,
  output logic [SRC_W-1:0]  edgeVec
);
  logic [SRC_W-1:0]  syncStage [SYNC_STAGES];
  logic [SRC_W-1:0]  reqSync;
  logic [SRC_W-1:0]  prevQ;
  logic [SRC_W-1:0]  statusVec;
  logic [SRC_W-1:0]  maskQ;
  logic [BANK_W-1:0] statusSel;
  logic [BANK_W-1:0] maskSel;
  logic [BANK_W-1:0] rdQ;

  // synchroniser chain and previous-value register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
      prevQ <= '0;
    end else begin
      syncStage[0] <= reqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      prevQ <= reqSync;
    end
  end

  assign reqSync = syncStage[SYNC_STAGES-1];
  assign edgeVec = reqSync & ~prevQ;

  // per-source capture: edge latch or live level
  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    if (i == LEVEL_SRC) begin : g_level
      assign statusVec[i]  = reqSync[i];
      assign latchedVec[i] = 1'b0;
    end else begin : g_edge
      logic latQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) latQ <= 1'b0;
        else       latQ <= (edgeVec[i] & maskQ[i]) |
                           (latQ & ~strobes.statusRd[i / BANK_W]);
      end
      assign statusVec[i]  = latQ;
      assign latchedVec[i] = latQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobes.maskWr[b]) maskQ[b*BANK_W +: BANK_W] <= busWdata;
      end
    end
  end

  always_comb begin
    statusSel = '0;
    maskSel   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobes.rdBank == BANK_SEL_W'(b)) begin
        statusSel = statusVec[b*BANK_W +: BANK_W];
        maskSel   = maskQ[b*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else begin
      case (strobes.rdKind)
        RD_STATUS: rdQ <= statusSel;
        RD_MASK:   rdQ <= maskSel;
        RD_ZERO:   rdQ <= '0;
        default:   rdQ <= rdQ;
      endcase
    end
  end

  assign busRdata = rdQ;
  assign irqOut   = |(statusVec & maskQ);
  assign maskVec  = maskQ;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_SRC   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BANK_W-1:0] busWdata,
  output logic [BANK_W-1:0] busRdata,
  input  logic [SRC_W-1:0]  reqIn,
  output logic              irqOut
);
  ctrlStrobes_t     strobes;
  logic [SRC_W-1:0] maskVec;
  logic [SRC_W-1:0] latchedVec;
  logic [SRC_W-1:0] edgeVec;

  irq_agg_ctrl u_ctrl (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  irq_agg_datapath #(
    .LEVEL_SRC   (LEVEL_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .busWdata   (busWdata),
    .strobes    (strobes),
    .busRdata   (busRdata),
    .irqOut     (irqOut),
    .maskVec    (maskVec),
    .latchedVec (latchedVec),
    .edgeVec    (edgeVec)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_SRC = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [BANK_W-1:0] busWdata,
  input logic [BANK_W-1:0] busRdata,
  input logic              irqOut,
  input logic [SRC_W-1:0]  maskVec,
  input logic [SRC_W-1:0]  latchedVec,
  input logic [SRC_W-1:0]  edgeVec
);
  // R1: quiet state while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (irqOut == 1'b0 && maskVec == '0 && latchedVec == '0)
        else $error("reset state not quiet");
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // R2: mask write lands in its byte
    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == {1'b1, BANK_SEL_W'(b)})
        |=> maskVec[b*BANK_W +: BANK_W] == $past(busWdata));
    // R5: a status read leaves only bits that were captured on that same edge
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
      (busRd && busAddr == {1'b0, BANK_SEL_W'(b)})
        |=> (latchedVec[b*BANK_W +: BANK_W] & ~$past(edgeVec[b*BANK_W +: BANK_W])) == '0);
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    // R4: a latch only rises if the source was enabled
    a_r4_masked_not_captured: assert property (@(posedge clk) disable iff (!rstN)
      $rose(latchedVec[i]) |-> $past(maskVec[i]));
    if (i != LEVEL_SRC) begin : g_edge
      // R6: an enabled edge is always held on the next cycle, even during a read
      a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
        (edgeVec[i] && maskVec[i]) |=> latchedVec[i]);
    end
  end

  // R8: nothing enabled means no request
  a_r8_low_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irqOut);

  // R9: unused offsets read as zero
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[BANK_SEL_W-1:0] == BANK_SEL_W'(NUM_BANKS)) |=> busRdata == '0);
endmodule

bind irq_aggregator irq_agg_chk #(.LEVEL_SRC(LEVEL_SRC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busRd      (busRd),
  .busWr      (busWr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .irqOut     (irqOut),
  .maskVec    (maskVec),
  .latchedVec (latchedVec),
  .edgeVec    (edgeVec)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int LVL = 13;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  busAddr;
  logic        busRd;
  logic        busWr;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata;
  logic [23:0] reqIn;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  irq_aggregator #(.LEVEL_SRC(LVL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .reqIn(reqIn), .irqOut(irqOut)
  );

  // behavioural model written from the requirements
  logic [23:0] mS1, mS2, mP, mLat, mMask;
  logic [7:0]  mRd;

  function automatic logic [23:0] statusOf(logic [23:0] lat, logic [23:0] lvl);
    return lat | (lvl & (24'h1 << LVL));
  endfunction

  function automatic logic expIrq();
    return |(statusOf(mLat, mS2) & mMask);
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    logic [23:0] edg, st, nxt;
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mP <= '0; mLat <= '0; mMask <= '0; mRd <= '0;
    end else begin
      edg = mS2 & ~mP;
      st  = statusOf(mLat, mS2);
      if (busRd) begin
        case (busAddr)
          3'd0: mRd <= st[7:0];
          3'd1: mRd <= st[15:8];
          3'd2: mRd <= st[23:16];
          3'd4: mRd <= mMask[7:0];
          3'd5: mRd <= mMask[15:8];
          3'd6: mRd <= mMask[23:16];
          default: mRd <= 8'h00;
        endcase
      end
      for (int i = 0; i < 24; i++) begin
        nxt[i] = (edg[i] & mMask[i]) |
                 (mLat[i] & ~(busRd && busAddr == 3'(i / 8)));
      end
      nxt[LVL] = 1'b0;
      mLat <= nxt;
      if (busWr) begin
        case (busAddr)
          3'd4: mMask[7:0]   <= busWdata;
          3'd5: mMask[15:8]  <= busWdata;
          3'd6: mMask[23:16] <= busWdata;
          default: ;
        endcase
      end
      mS1 <= reqIn;
      mS2 <= mS1;
      mP  <= mS2;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    tick();
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    tick();
    busWr = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    logic       rdPending;
    int         seedVal;
    rstN = 1'b0; busAddr = '0; busRd = 1'b0; busWr = 1'b0; busWdata = '0; reqIn = '0;
    repeat (3) @(negedge clk);
    chk("R1 irqOut in reset", 32'(irqOut), 0);
    rstN = 1'b1;
    tick();

    // R1 after release
    chk("R1 irqOut", 32'(irqOut), 0);
    rd(3'd4, d); chk("R1 mask0", 32'(d), 0);
    rd(3'd5, d); chk("R1 mask1", 32'(d), 0);
    rd(3'd6, d); chk("R1 mask2", 32'(d), 0);
    rd(3'd0, d); chk("R1 status0", 32'(d), 0);

    // R2 mask write and readback
    wr(3'd4, 8'hA5); wr(3'd5, 8'h3C); wr(3'd6, 8'h81);
    rd(3'd4, d); chk("R2 mask0", 32'(d), 32'hA5);
    rd(3'd5, d); chk("R2 mask1", 32'(d), 32'h3C);
    rd(3'd6, d); chk("R2 mask2", 32'(d), 32'h81);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);

    // R10 / R3 edge latency and capture on source 2
    reqIn[2] = 1'b1;
    tick(); chk("R10 irq after 1 edge", 32'(irqOut), 0);
    tick(); chk("R10 irq after 2 edges", 32'(irqOut), 0);
    tick(); chk("R10 irq after 3 edges", 32'(irqOut), 1);
    rd(3'd0, d); chk("R3 status0 bit2", 32'(d), 32'h04);
    chk("R5 irq cleared by read", 32'(irqOut), 0);

    // R5 bank independence: sources 9 and 17
    reqIn[9] = 1'b1; reqIn[17] = 1'b1;
    repeat (3) tick();
    rd(3'd0, d); chk("R5 status0 untouched", 32'(d), 0);
    rd(3'd2, d); chk("R3 status2 bit1", 32'(d), 32'h02);
    rd(3'd1, d); chk("R5 status1 kept", 32'(d), 32'h02);
    rd(3'd1, d); chk("R5 status1 cleared", 32'(d), 0);

    // R4 masked edge is lost
    wr(3'd4, 8'h00);
    reqIn[3] = 1'b1;
    repeat (3) tick();
    chk("R4 irq while masked", 32'(irqOut), 0);
    wr(3'd4, 8'hFF);
    chk("R4 irq after unmask", 32'(irqOut), 0);
    rd(3'd0, d); chk("R4 status0 after unmask", 32'(d), 0);

    // R6 edge captured on the read edge of its byte
    reqIn[4] = 1'b1;
    tick(); tick();
    rd(3'd0, d); chk("R6 read before capture", 32'(d), 0);
    chk("R6 irq kept", 32'(irqOut), 1);
    rd(3'd0, d); chk("R6 bit4 kept", 32'(d), 32'h10);

    // R7 level source
    reqIn[LVL] = 1'b1;
    tick(); chk("R10 level after 1 edge", 32'(irqOut), 0);
    tick(); chk("R7 level irq", 32'(irqOut), 1);
    rd(3'd1, d); chk("R7 level status", 32'(d), 32'h20);
    rd(3'd1, d); chk("R7 level not cleared", 32'(d), 32'h20);
    wr(3'd5, 8'h00);
    chk("R8 level masked irq", 32'(irqOut), 0);
    rd(3'd1, d); chk("R7 status ignores mask", 32'(d), 32'h20);
    reqIn[LVL] = 1'b0;
    tick(); tick();
    rd(3'd1, d); chk("R7 level follows input", 32'(d), 0);
    wr(3'd5, 8'hFF);

    // R9 unused offsets and status writes
    wr(3'd0, 8'hFF); wr(3'd3, 8'h00); wr(3'd7, 8'h00);
    rd(3'd0, d); chk("R9 status write ignored", 32'(d), 0);
    rd(3'd3, d); chk("R9 offset 3", 32'(d), 0);
    rd(3'd7, d); chk("R9 offset 7", 32'(d), 0);
    rd(3'd4, d); chk("R9 mask0 kept", 32'(d), 32'hFF);
    chk("R8 idle irq", 32'(irqOut), 0);

    // constrained random phase against the model
    seedVal = $urandom(32'd2024);
    rdPending = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (rdPending) chk("R3 R5 R6 R7 random read", 32'(busRdata), 32'(mRd));
      chk("R8 random irqOut", 32'(irqOut), 32'(expIrq()));
      reqIn    = reqIn ^ (24'($urandom) & 24'($urandom) & 24'($urandom));
      busRd    = ($urandom % 3) == 0;
      busWr    = ($urandom % 5) == 0;
      busAddr  = 3'($urandom % 8);
      busWdata = 8'($urandom);
      rdPending = busRd;
      tick();
    end
    busRd = 1'b0; busWr = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule